// File: doc/BRIEF.md
# Six-Channel PWM Controller with Committed Updates

This block generates six independent pulse-width-modulated outputs from one clock. Each channel has a clock divider, a period length and a high-time length, all counted in divided clock ticks. The channel's output is active while its counter is below the high-time. The counter restarts at the end of each period. A live polarity bit and a live output-type bit decide how that level reaches the pin.

Software writes new divider, period and high-time values into shadow registers over a simple 32-bit register bus. The running counters ignore those values until software commits them by raising the channel's trigger bit. A commit takes effect on the next clock and restarts the channel. If the channel's smooth bit was set before the commit, the new values are instead loaded at the next end of period, so that no pulse is cut short.

To disable a channel, software commits zero for the period, the high-time and the divider.

Top module: `pwm6_trig`

## Requirements
- R1: After reset every register reads zero, and every channel has pwm_o = 0 and pwm_oe = 0. At reset the channel is open-drain with polarity 0, so its output is released.
- R2: Register reads return the last written values, and undefined bits and unmapped offsets read zero.
  - Offset 0x00 is the control register. For channel n, bit n is the trigger, bit 8+n the polarity, bit 16+n the output type (1 = push-pull) and bit 24+n the smooth bit.
  - Offset 0x04 holds the 3-bit dividers, with channel n at bits 4n+2..4n.
  - Offset 0x08+8n is channel n's period and offset 0x0C+8n its high-time, each 24 bits wide.
- R3: Writes to the divider, period or high-time registers leave the running output unchanged until they are committed.
- R4: A commit is a control write that changes a channel's trigger bit from 0 to 1.
  - If that channel's smooth bit was 0 before the write, the shadow values load on the next clock edge and the counter restarts.
  - The counter then advances once every (divider+1) clocks and wraps after period-1.
  - The raw level is (counter < high-time). For period 0 or 1 the counter stays at 0.
- R5: A high-time of zero gives a constantly inactive level. A high-time at or above a nonzero period gives a constantly active level.
- R6: If the smooth bit was 1 before the commit, the shadow values load at the first period wrap after the commit. Until then the output follows the old settings.
- R7: Polarity 1 passes the raw level unchanged, and polarity 0 inverts it. A polarity change takes effect without a commit.
- R8: In push-pull mode, pwm_o equals the level and pwm_oe is 1. In open-drain mode, pwm_o is 0 and pwm_oe is the inverse of the level.
- R9: Committing zero for the period, the high-time and the divider holds the channel inactive.
- R10: A control write that leaves an already set trigger bit at 1 does not restart the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 6 | Per-channel output value |
| pwm_oe | output | 6 | Per-channel output enable |

## Verification
A wrong divider or period count changes the spacing of the edges on pwm_o within one period of the wrong setting. Every sample in a window is therefore compared against the waveform computed from the committed values. A shadow value that leaks into the running counters before its commit shows as an early change in the waveform. A smooth commit that loads at the wrong time appears as a misplaced switch between the old and new patterns, at the first period boundary after the commit.

// File: rtl/pwm6_trig.sv
module pwm6_trig #(
  parameter int NCH = 6,
  parameter int CW  = 24,
  parameter int PSW = 3,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] pwm_oe
);
  localparam int POL_B = 8;
  localparam int TYP_B = 16;
  localparam int SMT_B = 24;
  localparam int PS_STRIDE = 4;
  localparam int CH_BASE = 8;
  localparam int CH_STRIDE = 8;
  localparam int HI_OFS = 4;

  logic [NCH-1:0] trig, pol, typ, smth, imm_q, pend;
  logic [NCH-1:0] commit, tick, wrap, raw, lvl;
  logic [NCH-1:0][PSW-1:0] ps_sh, ps_act, ps_cnt;
  logic [NCH-1:0][CW-1:0] per_sh, hi_sh, per_act, hi_act, cnt;

  wire wr_ctrl = bus_we && (bus_addr == AW'(0));
  wire wr_ps   = bus_we && (bus_addr == AW'(4));

  assign commit = wr_ctrl ? (bus_wdata[NCH-1:0] & ~trig) : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign tick[g] = ps_cnt[g] >= ps_act[g];
    assign wrap[g] = tick[g] &&
                     ((per_act[g] <= CW'(1)) || (cnt[g] >= per_act[g] - CW'(1)));
    assign raw[g]    = cnt[g] < hi_act[g];
    assign lvl[g]    = pol[g] ? raw[g] : ~raw[g];
    assign pwm_o[g]  = typ[g] & lvl[g];
    assign pwm_oe[g] = typ[g] | ~lvl[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= '0; pol <= '0; typ <= '0; smth <= '0;
      imm_q <= '0; pend <= '0;
      ps_sh <= '0; ps_act <= '0; ps_cnt <= '0;
      per_sh <= '0; hi_sh <= '0; per_act <= '0; hi_act <= '0; cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        trig <= bus_wdata[NCH-1:0];
        pol  <= bus_wdata[POL_B +: NCH];
        typ  <= bus_wdata[TYP_B +: NCH];
        smth <= bus_wdata[SMT_B +: NCH];
      end
      imm_q <= commit & ~smth;
      for (int n = 0; n < NCH; n++) begin
        if (wr_ps)
          ps_sh[n] <= bus_wdata[PS_STRIDE*n +: PSW];
        if (bus_we && bus_addr == AW'(CH_BASE + CH_STRIDE*n))
          per_sh[n] <= bus_wdata[CW-1:0];
        if (bus_we && bus_addr == AW'(CH_BASE + CH_STRIDE*n + HI_OFS))
          hi_sh[n] <= bus_wdata[CW-1:0];

        if (commit[n])
          pend[n] <= smth[n];
        else if (wrap[n] && pend[n])
          pend[n] <= 1'b0;

        if (imm_q[n] || (wrap[n] && pend[n])) begin
          ps_act[n]  <= ps_sh[n];
          per_act[n] <= per_sh[n];
          hi_act[n]  <= hi_sh[n];
          cnt[n]     <= '0;
          ps_cnt[n]  <= '0;
        end else if (tick[n]) begin
          ps_cnt[n] <= '0;
          cnt[n]    <= wrap[n] ? '0 : cnt[n] + CW'(1);
        end else begin
          ps_cnt[n] <= ps_cnt[n] + PSW'(1);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0)) begin
      bus_rdata[NCH-1:0]     = trig;
      bus_rdata[POL_B +: NCH] = pol;
      bus_rdata[TYP_B +: NCH] = typ;
      bus_rdata[SMT_B +: NCH] = smth;
    end
    if (bus_addr == AW'(4))
      for (int n = 0; n < NCH; n++) bus_rdata[PS_STRIDE*n +: PSW] = ps_sh[n];
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(CH_BASE + CH_STRIDE*n))
        bus_rdata[CW-1:0] = per_sh[n];
      if (bus_addr == AW'(CH_BASE + CH_STRIDE*n + HI_OFS))
        bus_rdata[CW-1:0] = hi_sh[n];
    end
  end
endmodule

// File: rtl/pwm6_trig_chk.sv
module pwm6_trig_chk #(
  parameter int NCH = 6,
  parameter int CW  = 24,
  parameter int PSW = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCH-1:0]          imm_q,
  input logic [NCH-1:0]          pend,
  input logic [NCH-1:0]          pol,
  input logic [NCH-1:0]          typ,
  input logic [NCH-1:0][CW-1:0]  per_act,
  input logic [NCH-1:0][CW-1:0]  hi_act,
  input logic [NCH-1:0][CW-1:0]  cnt,
  input logic [NCH-1:0][PSW-1:0] ps_act,
  input logic [NCH-1:0][PSW-1:0] ps_cnt,
  input logic [NCH-1:0]          pwm_o,
  input logic [NCH-1:0]          pwm_oe
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(per_act[g]) |-> $past(imm_q[g] | pend[g])); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (per_act[g] > CW'(1)) |-> (cnt[g] < per_act[g])); // R4
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ps_cnt[g] <= ps_act[g]); // R4
    AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $past(imm_q[g]) |-> (cnt[g] == '0 && ps_cnt[g] == '0)); // R4
    AST_ZERO_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_act[g] == '0 && pol[g] && typ[g]) |-> !pwm_o[g]); // R5
    AST_FULL_HIGH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (per_act[g] != '0 && hi_act[g] >= per_act[g] && pol[g] && typ[g]) |-> pwm_o[g]); // R5
    AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !typ[g] |-> !pwm_o[g]); // R8
    AST_PP_ALWAYS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      typ[g] |-> pwm_oe[g]); // R8
  end
endmodule

bind pwm6_trig pwm6_trig_chk #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imm_q(imm_q), .pend(pend), .pol(pol), .typ(typ),
  .per_act(per_act), .hi_act(hi_act), .cnt(cnt), .ps_act(ps_act),
  .ps_cnt(ps_cnt), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
);

// File: tb/tb_pwm6_trig.sv
module tb_pwm6_trig;
  localparam int CLK_P = 10;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_o, pwm_oe;

  pwm6_trig dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int t = 0;
  always @(posedge clk) t <= t + 1;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] ctrl_sh = '0, pssh = '0;
  int a_p[NCH], a_per[NCH], a_hi[NCH], a_lt[NCH];
  int n_p[NCH], n_per[NCH], n_hi[NCH], n_lt[NCH];
  bit has_n[NCH];

  function automatic bit raw_of(int j, int p, int per, int hi);
    int c;
    c = j / (p + 1);
    c = (per > 1) ? c % per : 0;
    return c < hi;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic promote(int n);
    if (has_n[n] && t >= n_lt[n]) begin
      a_p[n] = n_p[n]; a_per[n] = n_per[n]; a_hi[n] = n_hi[n]; a_lt[n] = n_lt[n];
      has_n[n] = 0;
    end
  endtask

  task automatic check_win(int n, int cycles, input string tag);
    int i = 0;
    while (i < cycles || has_n[n]) begin
      bit r, lv, eo, eoe;
      @(negedge clk);
      promote(n);
      r = raw_of(t - a_lt[n], a_p[n], a_per[n], a_hi[n]);
      lv = ctrl_sh[8+n] ? r : !r;
      eo = ctrl_sh[16+n] & lv;
      eoe = ctrl_sh[16+n] | !lv;
      checks++;
      if (pwm_o[n] !== eo || pwm_oe[n] !== eoe) begin
        failures++;
        $display("FAIL %s ch%0d t=%0d actual o/oe=%b%b expected=%b%b",
                 tag, n, t, pwm_o[n], pwm_oe[n], eo, eoe);
      end
      i++;
    end
  endtask

  task automatic cfg(int n, int p, int per, int hi, bit sm, bit pl);
    int lper, len;
    ctrl_sh[n] = 1'b0; ctrl_sh[24+n] = sm; ctrl_sh[8+n] = pl; ctrl_sh[16+n] = 1'b1;
    wr(8'h00, ctrl_sh);
    pssh[4*n +: 3] = 3'(p);
    wr(8'h04, pssh);
    wr(8'(8 + 8*n), 32'(per));
    wr(8'(12 + 8*n), 32'(hi));
    ctrl_sh[n] = 1'b1; ctrl_sh[24+n] = 1'b0;
    wr(8'h00, ctrl_sh);
    n_p[n] = p; n_per[n] = per; n_hi[n] = hi; has_n[n] = 1;
    if (sm) begin
      lper = (a_per[n] > 1) ? a_per[n] : 1;
      len = (a_p[n] + 1) * lper;
      n_lt[n] = a_lt[n] + len * ((t - a_lt[n]) / len + 1);
    end else begin
      n_lt[n] = t + 1;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < NCH; n++) begin
      a_p[n] = 0; a_per[n] = 0; a_hi[n] = 0; a_lt[n] = 0; has_n[n] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pwm_o !== '0 || pwm_oe !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs actual o=%b oe=%b expected 0/0", pwm_o, pwm_oe);
    end
    rst_n = 1'b1;
    rd_chk(8'h00, 32'h0, "R1 ctrl");
    rd_chk(8'h04, 32'h0, "R1 prescale");
    rd_chk(8'h08, 32'h0, "R1 period ch0");
    rd_chk(8'h34, 32'h0, "R1 high ch5");
    checks++;
    if (pwm_o !== '0 || pwm_oe !== '0) begin
      failures++;
      $display("FAIL R1 idle outputs actual o=%b oe=%b expected 0/0", pwm_o, pwm_oe);
    end

    wr(8'h00, 32'hC0FF_FFC0);
    ctrl_sh = 32'h003F_3F00;
    rd_chk(8'h00, 32'h003F_3F00, "R2 ctrl fields");
    wr(8'h04, 32'hFFFF_FFFF);
    pssh = 32'h0077_7777;
    rd_chk(8'h04, 32'h0077_7777, "R2 prescale fields");
    wr(8'h18, 32'hAB12_3456);
    rd_chk(8'h18, 32'h0012_3456, "R2 period ch2");
    wr(8'h34, 32'hFFFF_FFFF);
    rd_chk(8'h34, 32'h00FF_FFFF, "R2 high ch5");
    rd_chk(8'h38, 32'h0, "R2 unmapped 0x38");
    rd_chk(8'h40, 32'h0, "R2 unmapped 0x40");

    cfg(0, 0, 6, 2, 0, 1);
    check_win(0, 30, "R4 immediate ch0");
    pssh[2:0] = 3'd5;
    wr(8'h04, pssh);
    wr(8'h08, 32'd3);
    wr(8'h0C, 32'd1);
    check_win(0, 30, "R3 staged ch0");
    wr(8'h00, ctrl_sh);
    check_win(0, 20, "R10 trigger held ch0");

    cfg(1, 1, 5, 5, 0, 1);
    check_win(1, 25, "R5 high=period ch1");
    cfg(1, 0, 4, 9, 0, 1);
    check_win(1, 15, "R5 high>period ch1");
    cfg(1, 0, 4, 0, 0, 1);
    check_win(1, 15, "R5 high=0 ch1");

    cfg(0, 1, 3, 1, 1, 1);
    check_win(0, 40, "R6 smooth ch0");
    cfg(2, 2, 9, 4, 0, 1);
    check_win(2, 10, "R4 ch2 base");
    cfg(2, 0, 5, 2, 1, 1);
    check_win(2, 40, "R6 smooth ch2");

    cfg(1, 0, 6, 2, 0, 1);
    ctrl_sh[9] = 1'b0;
    wr(8'h00, ctrl_sh);
    check_win(1, 24, "R7 polarity ch1");
    ctrl_sh[17] = 1'b0;
    wr(8'h00, ctrl_sh);
    check_win(1, 24, "R8 open-drain inv ch1");
    ctrl_sh[9] = 1'b1;
    wr(8'h00, ctrl_sh);
    check_win(1, 24, "R8 open-drain ch1");

    cfg(3, 2, 7, 3, 0, 1);
    check_win(3, 30, "R4 ch3");
    cfg(3, 0, 0, 0, 0, 1);
    check_win(3, 30, "R9 disable ch3");

    for (int it = 0; it < 14; it++) begin
      int n, p, per, hi;
      bit sm, pl;
      n = int'($urandom % NCH);
      p = int'($urandom % 4);
      per = 2 + int'($urandom % 11);
      hi = int'($urandom % 14);
      sm = 1'($urandom % 2);
      pl = 1'($urandom % 2);
      cfg(n, p, per, hi, sm, pl);
      check_win(n, 2 * (p + 1) * per + 10, sm ? "R6 random" : "R4 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule